// File: doc/BRIEF.md
# Turbo Energy-Budget Frequency Governor

This block picks the frequency operating point for a cluster of cores. Operating points are numbered from index 0, the lowest-voltage and most energy-efficient point, up to `NUM_PSTATES-1`, the highest turbo frequency. `GUAR_IDX` marks the guaranteed frequency. The operating system asks for a point on `os_req`. A request at or below the guaranteed index is followed exactly. A request above it only says that more performance is wanted, and the hardware then chooses how far above the guaranteed point to run.

On each evaluation interval (`sample_vld`), the block compares the measured power sample with the sustained power limit. When power is below the limit, the difference is added to an energy credit. When power is above the limit, the difference is drawn from the credit. The credit saturates at a programmable cap and never goes below zero. Turbo points are granted only while credit remains, so time spent idle buys a short burst above the sustained limit. Once the credit is gone, power is pulled back to the sustained level.

How many turbo steps are allowed depends on how many cores are active, through a small writable table. Power-gated cores draw nothing, so their share of the budget lets fewer active cores run higher. A thermal-throttle input overrides everything else and forces the minimum point.

Top module: `tgov_governor`

## Requirements
- R1: During and directly after reset, `op_idx` is 0 and `credit` is 0.
- R2: On a cycle with `sample_vld` high and `pwr_sample` at or below `pwr_limit`, `credit` grows by `pwr_limit - pwr_sample` on that edge and saturates at `credit_cap`. If the cap has been lowered below the current credit, the credit is set to the cap.
- R3: On a cycle with `sample_vld` high and `pwr_sample` above `pwr_limit`, `credit` shrinks by `pwr_sample - pwr_limit` on that edge and stops at 0.
- R4: On a cycle with `sample_vld` low and `throttle` low, neither `credit` nor `op_idx` changes.
- R5: On a sample with `throttle` low and `os_req` at or below `GUAR_IDX`, `op_idx` becomes exactly `os_req`.
- R6: On a sample with `throttle` low, `os_req` above `GUAR_IDX` and a nonzero updated credit, `op_idx` becomes `min(GUAR_IDX + step, NUM_PSTATES-1)`. Here `step` is the table entry for the current active-core count.
- R7: On a sample with `throttle` low and `os_req` above `GUAR_IDX`, if the updated credit is 0, `op_idx` becomes `GUAR_IDX` in that same interval. `op_idx` is never above `GUAR_IDX` while `credit` is 0.
- R8: The table is indexed by the number of ones in `core_active` (0 to `NUM_CORES`). Its reset contents are 0 for a count of 0 and `min(NUM_PSTATES-1-GUAR_IDX, NUM_CORES-k+1)` for a count k of 1 or more, so fewer active cores receive more turbo steps.
- R9: With `tbl_wr_en` high, `tbl_wr_data` is written to entry `tbl_wr_addr` on that edge. A sample in the same cycle still uses the old entry. A write to an address above `NUM_CORES` changes nothing.
- R10: With `throttle` high, `op_idx` becomes 0 on that edge whatever the request. The credit still updates on a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | One evaluation interval ends this cycle |
| pwr_sample | input | PWR_W | Energy consumed in the interval |
| pwr_limit | input | PWR_W | Sustained budget per interval |
| credit_cap | input | CREDIT_W | Maximum stored credit |
| os_req | input | IDX_W | Operating point requested by software |
| core_active | input | NUM_CORES | One bit per core that is powered and active |
| throttle | input | 1 | Thermal emergency, forces the minimum point |
| tbl_wr_en | input | 1 | Step table write strobe |
| tbl_wr_addr | input | CNT_W | Active-core count whose entry is written |
| tbl_wr_data | input | STEP_W | Number of turbo steps for that count |
| op_idx | output | IDX_W | Granted operating point |
| credit | output | CREDIT_W | Current energy credit |

## Verification
The bench drives the credit into its cap and holds it there, then lowers the cap below the stored credit. A governor that only clamps on increments would then keep credit above the cap. The bench burns the credit to exactly zero and below, which exposes both a wrap to a huge value and a turbo grant that lingers for one interval after the credit runs out. It changes the active-core mask while turbo is requested and writes the table in the same cycle as a sample, which catches a swapped table index and write-before-read ordering. It also issues a write to an out-of-range address that must alter nothing. Throttle is pulsed during both sample and idle cycles to show that it overrides the OS floor while leaving the credit accounting untouched.

// File: rtl/tgov_pkg.sv
package tgov_pkg;

    // Source of the next operating point decision
    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_THROTTLE,
        SRC_OS,
        SRC_GUAR,
        SRC_TURBO
    } op_src_e;

endpackage

// File: rtl/tgov_credit.sv
// Next energy credit: add headroom, subtract overdraw, clamp to [0, cap]
module tgov_credit #(
    parameter int PWR_W    = 12,
    parameter int CREDIT_W = 16
) (
    input  logic [CREDIT_W-1:0] credit_cur,
    input  logic [PWR_W-1:0]    pwr,
    input  logic [PWR_W-1:0]    limit,
    input  logic [CREDIT_W-1:0] cap,
    output logic [CREDIT_W-1:0] credit_nx
);
    localparam int SW = CREDIT_W + 2;

    logic signed [SW-1:0] s_cr, s_lim, s_pwr, s_cap, s_sum;

    always_comb begin
        s_cr  = $signed({2'b00, credit_cur});
        s_cap = $signed({2'b00, cap});
        s_lim = $signed({{(SW-PWR_W){1'b0}}, limit});
        s_pwr = $signed({{(SW-PWR_W){1'b0}}, pwr});
        s_sum = s_cr + s_lim - s_pwr;
        if (s_sum < 0)
            credit_nx = '0;
        else if (s_sum > s_cap)
            credit_nx = cap;
        else
            credit_nx = s_sum[CREDIT_W-1:0];
    end
endmodule

// File: rtl/tgov_active_count.sv
// Population count of the active-core mask
module tgov_active_count #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 3
) (
    input  logic [NUM_CORES-1:0] mask,
    output logic [CNT_W-1:0]     count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_CORES; i++)
            count = count + CNT_W'(mask[i]);
    end
endmodule

// File: rtl/tgov_step_table.sv
// Writable table: active-core count -> allowed turbo steps
module tgov_step_table #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 3,
    parameter int MAX_STEP  = 3,
    parameter int STEP_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_addr,
    input  logic [STEP_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  rd_addr,
    output logic [STEP_W-1:0] rd_step
);
    localparam int ENTRIES = NUM_CORES + 1;

    function automatic logic [STEP_W-1:0] reset_steps(input int k);
        int v;
        if (k == 0) begin
            v = 0;
        end else begin
            v = NUM_CORES - k + 1;
            if (v > MAX_STEP) v = MAX_STEP;
        end
        return STEP_W'(v);
    endfunction

    logic [STEP_W-1:0] tbl_d [ENTRIES];
    logic [STEP_W-1:0] tbl_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && wr_addr == CNT_W'(i))
                tbl_d[i] = wr_data;
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    tbl_q[g] <= reset_steps(g);
                else
                    tbl_q[g] <= tbl_d[g];
            end
        end
    endgenerate

    always_comb begin
        rd_step = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (rd_addr == CNT_W'(i))
                rd_step = tbl_q[i];
    end
endmodule

// File: rtl/tgov_governor.sv
// Energy-credit turbo governor: top level
module tgov_governor #(
    parameter int NUM_CORES   = 4,
    parameter int PWR_W       = 12,
    parameter int CREDIT_W    = 16,
    parameter int NUM_PSTATES = 8,
    parameter int GUAR_IDX    = 4,
    localparam int IDX_W      = $clog2(NUM_PSTATES),
    localparam int CNT_W      = $clog2(NUM_CORES + 1),
    localparam int MAX_STEP   = NUM_PSTATES - 1 - GUAR_IDX,
    localparam int STEP_W     = $clog2(MAX_STEP + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_vld,
    input  logic [PWR_W-1:0]     pwr_sample,
    input  logic [PWR_W-1:0]     pwr_limit,
    input  logic [CREDIT_W-1:0]  credit_cap,
    input  logic [IDX_W-1:0]     os_req,
    input  logic [NUM_CORES-1:0] core_active,
    input  logic                 throttle,
    input  logic                 tbl_wr_en,
    input  logic [CNT_W-1:0]     tbl_wr_addr,
    input  logic [STEP_W-1:0]    tbl_wr_data,
    output logic [IDX_W-1:0]     op_idx,
    output logic [CREDIT_W-1:0]  credit
);
    import tgov_pkg::*;

    localparam int TOP_IDX = NUM_PSTATES - 1;

    typedef struct packed {
        logic [CREDIT_W-1:0] credit;
        logic [IDX_W-1:0]    op;
    } gov_state_t;

    gov_state_t st_d, st_q;

    logic [CREDIT_W-1:0] credit_nx;
    logic [CNT_W-1:0]    act_cnt;
    logic [STEP_W-1:0]   step_sel;
    logic [IDX_W-1:0]    req_cap;
    logic [IDX_W:0]      turbo_sum;
    logic [IDX_W-1:0]    turbo_idx;
    op_src_e             src;

    tgov_credit #(
        .PWR_W    (PWR_W),
        .CREDIT_W (CREDIT_W)
    ) u_credit (
        .credit_cur (st_q.credit),
        .pwr        (pwr_sample),
        .limit      (pwr_limit),
        .cap        (credit_cap),
        .credit_nx  (credit_nx)
    );

    tgov_active_count #(
        .NUM_CORES (NUM_CORES),
        .CNT_W     (CNT_W)
    ) u_count (
        .mask  (core_active),
        .count (act_cnt)
    );

    tgov_step_table #(
        .NUM_CORES (NUM_CORES),
        .CNT_W     (CNT_W),
        .MAX_STEP  (MAX_STEP),
        .STEP_W    (STEP_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_addr (act_cnt),
        .rd_step (step_sel)
    );

    always_comb begin
        st_d = st_q;

        req_cap   = (int'(os_req) > TOP_IDX) ? IDX_W'(TOP_IDX) : os_req;
        turbo_sum = (IDX_W+1)'(GUAR_IDX) + (IDX_W+1)'(step_sel);
        turbo_idx = (turbo_sum > (IDX_W+1)'(TOP_IDX)) ? IDX_W'(TOP_IDX)
                                                      : turbo_sum[IDX_W-1:0];

        if (throttle)
            src = SRC_THROTTLE;
        else if (!sample_vld)
            src = SRC_HOLD;
        else if (int'(req_cap) <= GUAR_IDX)
            src = SRC_OS;
        else if (credit_nx == '0)
            src = SRC_GUAR;
        else
            src = SRC_TURBO;

        if (sample_vld)
            st_d.credit = credit_nx;

        case (src)
            SRC_THROTTLE: st_d.op = '0;
            SRC_OS:       st_d.op = req_cap;
            SRC_GUAR:     st_d.op = IDX_W'(GUAR_IDX);
            SRC_TURBO:    st_d.op = turbo_idx;
            default:      st_d.op = st_q.op;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign op_idx = st_q.op;
    assign credit = st_q.credit;

endmodule

// File: rtl/tgov_chk.sv
// Property checker attached to the governor
module tgov_chk #(
    parameter int NUM_CORES   = 4,
    parameter int PWR_W       = 12,
    parameter int CREDIT_W    = 16,
    parameter int NUM_PSTATES = 8,
    parameter int GUAR_IDX    = 4,
    localparam int IDX_W      = $clog2(NUM_PSTATES)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sample_vld,
    input logic [CREDIT_W-1:0] credit_cap,
    input logic [IDX_W-1:0]    os_req,
    input logic                throttle,
    input logic [IDX_W-1:0]    op_idx,
    input logic [CREDIT_W-1:0] credit
);
    // R2: after a sample the credit never exceeds the cap seen at that sample
    p_cap_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> credit <= $past(credit_cap));

    // R4: idle cycles leave the state alone
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld && !throttle) |=> ($stable(credit) && $stable(op_idx)));

    // R5: requests in the software range are granted exactly
    p_os_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !throttle && int'(os_req) <= GUAR_IDX)
        |=> op_idx == $past(os_req));

    // R6: a turbo request is never answered below the guaranteed point
    p_turbo_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !throttle && int'(os_req) > GUAR_IDX)
        |=> int'(op_idx) >= GUAR_IDX);

    // R7: no turbo point while the credit is empty
    p_no_turbo_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(op_idx) > GUAR_IDX |-> credit != '0);

    // R10: throttle forces the minimum point
    p_throttle_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        throttle |=> op_idx == '0);

endmodule

bind tgov_governor tgov_chk #(
    .NUM_CORES   (NUM_CORES),
    .PWR_W       (PWR_W),
    .CREDIT_W    (CREDIT_W),
    .NUM_PSTATES (NUM_PSTATES),
    .GUAR_IDX    (GUAR_IDX)
) u_chk (.*);

// File: tb/sim_tgov_governor.sv
module sim_tgov_governor;
    localparam int NUM_CORES   = 4;
    localparam int PWR_W       = 12;
    localparam int CREDIT_W    = 16;
    localparam int NUM_PSTATES = 8;
    localparam int GUAR_IDX    = 4;
    localparam int IDX_W       = $clog2(NUM_PSTATES);
    localparam int CNT_W       = $clog2(NUM_CORES + 1);
    localparam int TOP_IDX     = NUM_PSTATES - 1;
    localparam int MAX_STEP    = TOP_IDX - GUAR_IDX;
    localparam int STEP_W      = $clog2(MAX_STEP + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_vld = 1'b0;
    logic [PWR_W-1:0]     pwr_sample = '0;
    logic [PWR_W-1:0]     pwr_limit = '0;
    logic [CREDIT_W-1:0]  credit_cap = '0;
    logic [IDX_W-1:0]     os_req = '0;
    logic [NUM_CORES-1:0] core_active = '0;
    logic                 throttle = 1'b0;
    logic                 tbl_wr_en = 1'b0;
    logic [CNT_W-1:0]     tbl_wr_addr = '0;
    logic [STEP_W-1:0]    tbl_wr_data = '0;
    logic [IDX_W-1:0]     op_idx;
    logic [CREDIT_W-1:0]  credit;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int m_credit = 0;
    int m_op = 0;
    int m_tbl [NUM_CORES+1];
    bit m_written [NUM_CORES+1];

    always #10 clk = ~clk;

    tgov_governor #(
        .NUM_CORES   (NUM_CORES),
        .PWR_W       (PWR_W),
        .CREDIT_W    (CREDIT_W),
        .NUM_PSTATES (NUM_PSTATES),
        .GUAR_IDX    (GUAR_IDX)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_vld  (sample_vld),
        .pwr_sample  (pwr_sample),
        .pwr_limit   (pwr_limit),
        .credit_cap  (credit_cap),
        .os_req      (os_req),
        .core_active (core_active),
        .throttle    (throttle),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_addr (tbl_wr_addr),
        .tbl_wr_data (tbl_wr_data),
        .op_idx      (op_idx),
        .credit      (credit)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input int p, input int l, input int c, input int r,
                       input logic [NUM_CORES-1:0] a, input bit t,
                       input bit we, input int wa, input int wd);
        int sum, ncred, nop, cnt, rq;
        string ctag, otag;
        sample_vld  = v;
        pwr_sample  = PWR_W'(p);
        pwr_limit   = PWR_W'(l);
        credit_cap  = CREDIT_W'(c);
        os_req      = IDX_W'(r);
        core_active = a;
        throttle    = t;
        tbl_wr_en   = we;
        tbl_wr_addr = CNT_W'(wa);
        tbl_wr_data = STEP_W'(wd);
        cnt = 0;
        for (int i = 0; i < NUM_CORES; i++) cnt += int'(a[i]);
        sum = m_credit + l - p;
        ncred = m_credit;
        if (v) ncred = (sum < 0) ? 0 : ((sum > c) ? c : sum);
        ctag = !v ? "R4" : ((p <= l) ? "R2" : "R3");
        rq = (r > TOP_IDX) ? TOP_IDX : r;
        nop = m_op;
        if (t) begin
            nop = 0; otag = "R10";
        end else if (!v) begin
            otag = "R4";
        end else if (rq <= GUAR_IDX) begin
            nop = rq; otag = "R5";
        end else if (ncred == 0) begin
            nop = GUAR_IDX; otag = "R7";
        end else begin
            nop = GUAR_IDX + m_tbl[cnt];
            if (nop > TOP_IDX) nop = TOP_IDX;
            otag = m_written[cnt] ? "R9" : "R6 R8";
        end
        @(posedge clk);
        m_credit = ncred;
        m_op = nop;
        if (we && wa <= NUM_CORES) begin
            m_tbl[wa] = wd;
            m_written[wa] = 1'b1;
        end
        @(negedge clk);
        check(ctag, "credit", int'(credit), m_credit);
        check(otag, "op_idx", int'(op_idx), m_op);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k <= NUM_CORES; k++) begin
            m_tbl[k] = (k == 0) ? 0 : ((NUM_CORES - k + 1 > MAX_STEP) ? MAX_STEP : NUM_CORES - k + 1);
            m_written[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "op_idx in reset", int'(op_idx), 0);
        check("R1", "credit in reset", int'(credit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "op_idx after reset", int'(op_idx), 0);
        check("R1", "credit after reset", int'(credit), 0);

        // R2 build credit to saturation, R5 OS range
        for (int i = 0; i < 8; i++) cyc(1, 20, 100, 500, 2, 4'b0001, 0, 0, 0, 0);
        // R4 idle cycles
        for (int i = 0; i < 3; i++) cyc(0, 900, 100, 500, 7, 4'b1111, 0, 0, 0, 0);
        // R6 R8 turbo under different active counts
        cyc(1, 150, 100, 500, 7, 4'b0001, 0, 0, 0, 0);
        cyc(1, 150, 100, 500, 7, 4'b1111, 0, 0, 0, 0);
        cyc(1, 150, 100, 500, 7, 4'b0111, 0, 0, 0, 0);
        cyc(1, 150, 100, 500, 6, 4'b0000, 0, 0, 0, 0);
        // R2 lowered cap below stored credit
        cyc(1, 100, 100, 120, 7, 4'b0011, 0, 0, 0, 0);
        // R3 R7 burn credit to zero
        cyc(1, 600, 100, 500, 7, 4'b0001, 0, 0, 0, 0);
        cyc(1, 600, 100, 500, 7, 4'b0001, 0, 0, 0, 0);
        cyc(1, 100, 100, 500, 7, 4'b0001, 0, 0, 0, 0);
        // R9 write in same cycle as sample: old entry used, new entry next
        cyc(1, 40, 100, 500, 7, 4'b0001, 0, 1, 1, 1);
        cyc(1, 40, 100, 500, 7, 4'b0001, 0, 0, 0, 0);
        // R9 out of range address changes nothing
        cyc(0, 40, 100, 500, 7, 4'b0001, 0, 1, 6, 3);
        for (int k = 1; k <= NUM_CORES; k++)
            cyc(1, 100, 100, 500, 7, NUM_CORES'((1 << k) - 1), 0, 0, 0, 0);
        // R10 throttle with and without sample
        cyc(1, 40, 100, 500, 7, 4'b0001, 1, 0, 0, 0);
        cyc(0, 40, 100, 500, 3, 4'b0001, 1, 0, 0, 0);
        cyc(0, 40, 100, 500, 3, 4'b0001, 0, 0, 0, 0);
        cyc(1, 40, 100, 500, 3, 4'b0001, 0, 0, 0, 0);
        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            cyc($urandom_range(0, 1) == 0,
                $urandom_range(0, 300), $urandom_range(50, 200),
                $urandom_range(0, 1500), $urandom_range(0, TOP_IDX),
                NUM_CORES'($urandom_range(0, (1 << NUM_CORES) - 1)),
                $urandom_range(0, 19) == 0,
                $urandom_range(0, 19) == 0, $urandom_range(0, 7), $urandom_range(0, MAX_STEP));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule